// File: doc/BRIEF.md
# Reset Cause Discriminator

This block owns a shared, active-low reset line that several devices on a board may pull down. It can only pull the line low through an open-drain enable and never drives it high. When one of two internal fault detectors fires, either a watchdog timeout or a clock-monitor failure, the block pulls the line low for a fixed number of cycles. It then lets go, waits a fixed number of cycles, and reads the line again. If the line has returned high, the fault was the only cause, and the block reports the matching fault vector. If the line is still low, another device is holding reset, and the block reports the ordinary external reset vector.

The internal reset it gives to the rest of the chip falls as soon as the line goes low or the block's own asynchronous reset is applied, with no clock involved. It rises only on a clock edge, once the synchronized line reads high again. The vector-select code stays fixed while the chip runs, so the fetch logic can read it at any time after reset ends.

Top module: `reset_cause_ctrl`

## Requirements
- R1: While `arst_n` is low, `pin_pull_low` is 0, `vec_sel` is 00 and `sys_rst_n` is 0, all without a clock edge. After `arst_n` is released with the line high, `sys_rst_n` rises within 5 cycles.
- R2: `sys_rst_n` goes low as soon as `pin_in` goes low, without waiting for a clock edge.
- R3: A fault sampled on a clock edge while running turns on `pin_pull_low` for exactly DRIVE_CYCLES (16) consecutive cycles, starting after that edge.
- R4: SAMPLE_DELAY (8) cycles after the pull ends, the synchronized line is sampled. If it is high, `vec_sel` becomes 01 for a watchdog fault or 10 for a clock-monitor fault.
- R5: If the line is still low at that sample, `vec_sel` becomes 00, the external reset code.
- R6: When both faults are sampled on the same edge, the clock-monitor code 10 wins.
- R7: An external reset held low for at least 32 cycles that begins together with a fault always gives `vec_sel` 00.
- R8: For a fault-only reset, `sys_rst_n` stays low for DRIVE_CYCLES + SAMPLE_DELAY + 1 (25) cycles after the fault edge, and it is low whenever `pin_pull_low` is 1. It rises only on a clock edge, after `pin_in` has read high.
- R9: `vec_sel` never changes while `sys_rst_n` is high.
- R10: Fault inputs that arrive during a reset sequence have no effect: the pull length stays 16 and the vector comes from the first fault.
- R11: An external low on the line while running, with no fault, never turns on `pin_pull_low` and gives `vec_sel` 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous power-on reset of the block, active low |
| wdog_fault | input | 1 | Watchdog timeout request, sampled on the clock |
| cmon_fault | input | 1 | Clock-monitor failure request, sampled on the clock |
| pin_in | input | 1 | Level read back from the reset line |
| pin_pull_low | output | 1 | Open-drain pull-down enable for the reset line |
| sys_rst_n | output | 1 | Internal reset to the chip, active low |
| vec_sel | output | 2 | Reset vector select: 00 external, 01 watchdog, 10 clock monitor |

## Verification
The bench targets the edges of the sampling window. An external hold that ends well before the sample must still give the fault vector, and one that lasts 32 cycles or more must give 00. A design that samples early or late, or that skips the synchronizer, would return the wrong code in one of these two bands. It also checks faults that arrive together, where a wrong priority returns 01, and a second fault during the pull, which a design that restarts its sequence would show as a longer pull or a changed code. Finally it checks that the line going low or `arst_n` falling between clock edges drops `sys_rst_n` at once. A design that registered that path would show the drop one edge late.

// File: rtl/rcu_pkg.sv
package rcu_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRIVE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_HOLD  = 2'd3
    } rcu_state_e;

    localparam logic [1:0] VEC_EXT  = 2'b00;
    localparam logic [1:0] VEC_WDOG = 2'b01;
    localparam logic [1:0] VEC_CMON = 2'b10;

    typedef struct packed {
        rcu_state_e state;
        logic [1:0] cause;
        logic [1:0] vec;
    } rcu_ctl_t;

endpackage

// File: rtl/rcu_sync.sv
module rcu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = async_in;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], async_in};
        end
    endgenerate

    // Resets to "line low" so the block waits for the line after power-up
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= chain_d;
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/rcu_timer.sv
module rcu_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)              cnt_d = load_val;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/rcu_cause.sv
module rcu_cause
    import rcu_pkg::*;
(
    input  logic       wdog_fault,
    input  logic       cmon_fault,
    output logic       fault_any,
    output logic [1:0] fault_code
);
    always_comb begin
        fault_any  = wdog_fault | cmon_fault;
        fault_code = VEC_EXT;
        if (cmon_fault)      fault_code = VEC_CMON;
        else if (wdog_fault) fault_code = VEC_WDOG;
    end
endmodule

// File: rtl/rcu_fsm.sv
module rcu_fsm
    import rcu_pkg::*;
#(
    parameter int DRIVE_CYCLES = 16,
    parameter int SAMPLE_DELAY = 8,
    parameter int CW           = 5
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          pin_hi,
    input  logic          fault_any,
    input  logic [1:0]    fault_code,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          pull_low,
    output logic          running,
    output logic [1:0]    vec_sel
);
    localparam logic [CW-1:0] DRIVE_LOAD  = CW'(DRIVE_CYCLES - 1);
    localparam logic [CW-1:0] SAMPLE_LOAD = CW'(SAMPLE_DELAY - 1);

    rcu_ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (ctl_q.state)
            ST_RUN: begin
                if (fault_any) begin
                    ctl_d.state = ST_DRIVE;
                    ctl_d.cause = fault_code;
                    tmr_load    = 1'b1;
                    tmr_val     = DRIVE_LOAD;
                end else if (!pin_hi) begin
                    ctl_d.state = ST_HOLD;
                    ctl_d.vec   = VEC_EXT;
                end
            end
            ST_DRIVE: begin
                if (tmr_done) begin
                    ctl_d.state = ST_WAIT;
                    tmr_load    = 1'b1;
                    tmr_val     = SAMPLE_LOAD;
                end
            end
            ST_WAIT: begin
                if (tmr_done) begin
                    ctl_d.state = ST_HOLD;
                    ctl_d.vec   = pin_hi ? ctl_q.cause : VEC_EXT;
                end
            end
            ST_HOLD: begin
                if (pin_hi) ctl_d.state = ST_RUN;
            end
            default: ctl_d.state = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            ctl_q.state <= ST_HOLD;
            ctl_q.cause <= VEC_EXT;
            ctl_q.vec   <= VEC_EXT;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign pull_low = (ctl_q.state == ST_DRIVE);
    assign running  = (ctl_q.state == ST_RUN);
    assign vec_sel  = ctl_q.vec;
endmodule

// File: rtl/reset_cause_ctrl.sv
module reset_cause_ctrl #(
    parameter int DRIVE_CYCLES = 16,
    parameter int SAMPLE_DELAY = 8,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       arst_n,
    input  logic       wdog_fault,
    input  logic       cmon_fault,
    input  logic       pin_in,
    output logic       pin_pull_low,
    output logic       sys_rst_n,
    output logic [1:0] vec_sel
);
    localparam int MAXC = (DRIVE_CYCLES > SAMPLE_DELAY) ? DRIVE_CYCLES : SAMPLE_DELAY;
    localparam int CW   = $clog2(MAXC + 1);

    logic          pin_hi;
    logic          fault_any;
    logic [1:0]    fault_code;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_done;
    logic          running;

    rcu_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .arst_n   (arst_n),
        .async_in (pin_in),
        .sync_out (pin_hi)
    );

    rcu_cause u_cause (
        .wdog_fault (wdog_fault),
        .cmon_fault (cmon_fault),
        .fault_any  (fault_any),
        .fault_code (fault_code)
    );

    rcu_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .arst_n   (arst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    rcu_fsm #(
        .DRIVE_CYCLES (DRIVE_CYCLES),
        .SAMPLE_DELAY (SAMPLE_DELAY),
        .CW           (CW)
    ) u_fsm (
        .clk        (clk),
        .arst_n     (arst_n),
        .pin_hi     (pin_hi),
        .fault_any  (fault_any),
        .fault_code (fault_code),
        .tmr_done   (tmr_done),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .pull_low   (pin_pull_low),
        .running    (running),
        .vec_sel    (vec_sel)
    );

    // Entry is combinational on the raw line and arst_n; exit waits for a registered run state
    assign sys_rst_n = arst_n & pin_in & running;
endmodule

// File: rtl/rcu_checker.sv
module rcu_checker #(
    parameter int DRIVE_CYCLES = 16
) (
    input logic       clk,
    input logic       arst_n,
    input logic       pin_in,
    input logic       pin_pull_low,
    input logic       sys_rst_n,
    input logic [1:0] vec_sel
);
    localparam int RW = $clog2(DRIVE_CYCLES + 2) + 1;
    localparam logic [RW-1:0] RMAX = '1;

    logic [RW-1:0] pull_run_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)            pull_run_q <= '0;
        else if (!pin_pull_low) pull_run_q <= '0;
        else if (pull_run_q != RMAX) pull_run_q <= pull_run_q + 1'b1;
    end

    // R3: each pull burst lasts exactly DRIVE_CYCLES cycles
    p_pull_len_r3: assert property (@(posedge clk) disable iff (!arst_n)
        $fell(pin_pull_low) |-> (pull_run_q == RW'(DRIVE_CYCLES)));

    // R2: a low line always means internal reset
    p_async_entry_r2: assert property (@(posedge clk) disable iff (!arst_n)
        !pin_in |-> !sys_rst_n);

    // R8: pulling the line is only done while the chip is held in reset
    p_pull_in_reset_r8: assert property (@(posedge clk) disable iff (!arst_n)
        pin_pull_low |-> !sys_rst_n);

    // R8: release only after the line has read high
    p_release_r8: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(sys_rst_n) |-> ($past(pin_in) && pin_in));

    // R9: vector held while running
    p_vec_stable_r9: assert property (@(posedge clk) disable iff (!arst_n)
        (sys_rst_n && $past(sys_rst_n)) |-> $stable(vec_sel));

    // R4: only the three defined codes appear
    p_vec_legal_r4: assert property (@(posedge clk) disable iff (!arst_n)
        vec_sel != 2'b11);
endmodule

bind reset_cause_ctrl rcu_checker #(.DRIVE_CYCLES(DRIVE_CYCLES)) u_rcu_chk (
    .clk          (clk),
    .arst_n       (arst_n),
    .pin_in       (pin_in),
    .pin_pull_low (pin_pull_low),
    .sys_rst_n    (sys_rst_n),
    .vec_sel      (vec_sel)
);

// File: tb/reset_cause_ctrl_tb.sv
module reset_cause_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DRIVE      = 16;
    localparam int DELAY      = 8;

    logic       clk = 1'b0;
    logic       arst_n = 1'b0;
    logic       wdog_fault = 1'b0;
    logic       cmon_fault = 1'b0;
    logic       ext_low = 1'b0;
    logic       pin_in;
    logic       pin_pull_low;
    logic       sys_rst_n;
    logic [1:0] vec_sel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Wired-AND line: either party pulling gives a low level
    assign pin_in = ~(pin_pull_low | ext_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    reset_cause_ctrl u_dut (
        .clk          (clk),
        .arst_n       (arst_n),
        .wdog_fault   (wdog_fault),
        .cmon_fault   (cmon_fault),
        .pin_in       (pin_in),
        .pin_pull_low (pin_pull_low),
        .sys_rst_n    (sys_rst_n),
        .vec_sel      (vec_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_vec(input bit wd, input bit cm, input int ext_len);
        if (!wd && !cm)   return 0;
        if (ext_len >= 32) return 0;
        return cm ? 2 : 1;
    endfunction

    int last_pull, last_low, last_vec;

    task automatic run_case(input bit wd, input bit cm, input int ext_len, input int late_cm);
        int ext_left = ext_len;
        int cyc = 0;
        last_pull = 0;
        last_low  = 0;
        @(negedge clk);
        wdog_fault = wd;
        cmon_fault = cm;
        ext_low    = (ext_len > 0);
        while (cyc < 400) begin
            @(negedge clk);
            cyc++;
            wdog_fault = 1'b0;
            cmon_fault = (cyc == late_cm);
            if (ext_left > 0) begin
                ext_left--;
                if (ext_left == 0) ext_low = 1'b0;
            end
            if (pin_pull_low) last_pull++;
            if (!sys_rst_n) last_low++;
            else break;
        end
        cmon_fault = 1'b0;
        last_vec = int'(vec_sel);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        int rel;
        seed = $urandom(32'd20250611);
        // R1: reset state with no clock edge needed
        #1;
        check("R1 pull in reset", int'(pin_pull_low), 0);
        check("R1 vec in reset", int'(vec_sel), 0);
        check("R1 sys_rst_n in reset", int'(sys_rst_n), 0);
        @(negedge clk);
        arst_n = 1'b1;
        rel = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (sys_rst_n && rel == 0) rel = 1;
        end
        check("R1 release after arst", rel, 1);

        // R4: watchdog only
        run_case(1, 0, 0, 0);
        check("R3 pull length wdog", last_pull, DRIVE);
        check("R8 reset length wdog", last_low, DRIVE + DELAY + 1);
        check("R4 vec wdog", last_vec, 1);

        // R9: vector holds while running
        repeat (7) @(negedge clk);
        check("R9 vec stable", int'(vec_sel), 1);

        // R4: clock monitor only
        run_case(0, 1, 0, 0);
        check("R4 vec cmon", last_vec, 2);
        check("R3 pull length cmon", last_pull, DRIVE);

        // R6: both together
        run_case(1, 1, 0, 0);
        check("R6 vec both", last_vec, 2);

        // R10: second fault during the pull is ignored
        run_case(1, 0, 0, 5);
        check("R10 pull length", last_pull, DRIVE);
        check("R10 vec first cause", last_vec, 1);

        // R7: external exactly 32 cycles with both faults
        run_case(1, 1, 32, 0);
        check("R7 vec ext32", last_vec, 0);

        // R5: external far past the sample point with watchdog
        run_case(1, 0, 45, 0);
        check("R5 vec ext long", last_vec, 0);

        // R4: short external overlap ends before sample
        run_case(0, 1, 4, 0);
        check("R4 vec short ext", last_vec, 2);
        check("R8 reset length short ext", last_low, DRIVE + DELAY + 1);

        // R2: async entry from the line between edges
        @(negedge clk);
        #1 ext_low = 1'b1;
        #1 check("R2 async line", int'(sys_rst_n), 0);
        repeat (6) @(negedge clk);
        check("R11 no pull on ext", int'(pin_pull_low), 0);
        ext_low = 1'b0;
        repeat (6) @(negedge clk);
        check("R11 vec ext", int'(vec_sel), 0);
        check("R11 released", int'(sys_rst_n), 1);

        // R1/R2: arst_n mid-cycle
        run_case(1, 0, 0, 0);
        @(negedge clk);
        #1 arst_n = 1'b0;
        #1;
        check("R1 async arst vec", int'(vec_sel), 0);
        check("R2 async arst rst", int'(sys_rst_n), 0);
        @(negedge clk);
        arst_n = 1'b1;
        repeat (5) @(negedge clk);

        // Random mix
        for (int n = 0; n < 60; n++) begin
            int kind = int'($urandom_range(0, 4));
            bit wd = 0, cm = 0;
            int el = 0;
            case (kind)
                0: wd = 1;
                1: cm = 1;
                2: begin wd = 1; cm = 1; end
                3: begin wd = $urandom_range(0,1); cm = !wd | $urandom_range(0,1);
                         el = $urandom_range(0,1) ? int'($urandom_range(32, 60))
                                                  : int'($urandom_range(1, 10)); end
                default: el = int'($urandom_range(3, 40));
            endcase
            run_case(wd, cm, el, 0);
            check("R4 R5 R6 R7 random vec", last_vec, exp_vec(wd, cm, el));
            check("R3 R11 random pull", last_pull, (wd || cm) ? DRIVE : 0);
            repeat (int'($urandom_range(1, 6))) @(negedge clk);
            check("R9 random vec hold", int'(vec_sel), exp_vec(wd, cm, el));
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule